// File: doc/BRIEF.md
# Synchronous Rectifier Gate Sequencer

This block is the digital control core of a secondary-side synchronous rectifier driver. It receives three comparator flags that are already digital and come from the switch drain-to-source voltage. The turn-on flag means the voltage is strongly negative, so the body diode is conducting. The turn-off flag means the voltage is near zero. The reset flag means the voltage is positive. From these flags the block decides when the rectifier switch gate is enabled. A supply-good flag and an enable pin are also inputs.

When the block is armed, the turn-on flag closes the gate. A minimum on-time then hides the turn-off flag, so ringing cannot end conduction early. Once that window has passed, the turn-off flag opens the gate. A blanking window then hides the turn-on flag, so residual diode current cannot fire a second pulse. The positive reset flag ends this blanking early.

Both window lengths are clock-cycle counts on configuration inputs. A count of zero removes that window. A low supply forces lockout from any state. A filtered enable pin selects sleep. Every asynchronous input passes through a two-flop synchronizer. The gate and the state code are both registered.

Top module: `sr_gate_seq`

## Requirements
- R1: After reset, and from any state whenever the synchronized supply-good flag is low, the state code is 0 (lockout) and the gate is low. Lockout takes priority over sleep. A supply-good drop becomes visible at the third rising edge after the input changes.
- R2: When supply-good is high and the filtered enable is high, lockout (0) and sleep (1) both go directly to armed (code 2). No blanking is pending, so a turn-on flag that follows is honoured immediately.
- R3: In armed, a turn-on flag drives the gate high at the third rising edge after the flag rises. The state becomes on-masked (code 3), or on (code 4) when the minimum on-time count is zero.
- R4: The on-masked state lasts exactly `mot_cycles` clock cycles and then moves to on. The turn-off flag has no effect while the state is on-masked.
- R5: In the on state, a turn-off flag drives the gate low at the third rising edge after it rises. The state becomes blanked (code 5), or armed when the blanking count is zero.
- R6: The blanked state lasts exactly `blank_cycles` cycles and then returns to armed. The turn-on flag has no effect while the state is blanked.
- R7: A positive reset flag during blanking ends the window early and gives armed at the third rising edge after the flag rises.
- R8: When supply-good is high and the filtered enable is low, the state is sleep (code 1) and the gate stays low whatever the comparator flags do.
- R9: The enable pin must stay high for at least EN_RISE_CYC consecutive cycles, or low for at least EN_FALL_CYC consecutive cycles, before the filtered enable follows it. The state then changes at rising edge EN_RISE_CYC+3 or EN_FALL_CYC+3 after the pin changes. Shorter pulses change nothing.
- R10: The gate is high exactly when the state code is 3 or 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply above turn-on level (asynchronous) |
| enable | input | 1 | Enable pin, low requests sleep (asynchronous) |
| on_flag | input | 1 | Drain voltage below turn-on threshold |
| off_flag | input | 1 | Drain voltage above turn-off threshold |
| pos_flag | input | 1 | Drain voltage above positive reset threshold |
| mot_cycles | input | CW | Minimum on-time in cycles, 0 disables |
| blank_cycles | input | CW | Turn-on blanking in cycles, 0 disables |
| gate | output | 1 | Registered gate enable |
| state_o | output | 3 | State code: 0 lockout, 1 sleep, 2 armed, 3 on-masked, 4 on, 5 blanked |

## Verification
Each flag or supply change passes two synchronizer flops and then the state register. Its effect is therefore due at the third rising edge after the change. An enable change is due at the edge that follows the filter threshold plus three. The bench changes inputs on falling edges, counts rising edges from there, and samples on the following falling edge. At each boundary it checks the cycle just before the change is due as well as the cycle of the change. The sweeps over the window lengths compare the state and the gate in every cycle against cycle numbers worked out from the two counts.

// File: rtl/sr_gate_seq_pkg.sv
package sr_gate_seq_pkg;
  typedef enum logic [2:0] {
    ST_LOCKOUT = 3'd0,
    ST_SLEEP   = 3'd1,
    ST_ARMED   = 3'd2,
    ST_ON_MASK = 3'd3,
    ST_ON      = 3'd4,
    ST_BLANK   = 3'd5
  } sr_state_e;
endpackage

// File: rtl/sr_sync.sv
module sr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sr_en_filter.sv
module sr_en_filter #(
  parameter int RISE_CYC = 2000,
  parameter int FALL_CYC = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic filt
);
  localparam int MAXC = (RISE_CYC > FALL_CYC) ? RISE_CYC : FALL_CYC;
  localparam int FW   = $clog2(MAXC + 1);

  logic [FW-1:0] cnt;
  logic [FW-1:0] lim;

  // the filtered level flips once the opposite level has been seen lim+1 cycles in a row
  assign lim = filt ? FW'(FALL_CYC - 1) : FW'(RISE_CYC - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      filt <= 1'b0;
      cnt  <= '0;
    end else if (raw == filt) begin
      cnt <= '0;
    end else if (cnt == lim) begin
      filt <= raw;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sr_mask_timer.sv
module sr_mask_timer #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= len;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  // high during the final cycle of the loaded window
  assign last = (cnt == CW'(1));
endmodule

// File: rtl/sr_gate_seq.sv
module sr_gate_seq
  import sr_gate_seq_pkg::*;
#(
  parameter int CW          = 12,
  parameter int EN_RISE_CYC = 2000,
  parameter int EN_FALL_CYC = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          supply_ok,
  input  logic          enable,
  input  logic          on_flag,
  input  logic          off_flag,
  input  logic          pos_flag,
  input  logic [CW-1:0] mot_cycles,
  input  logic [CW-1:0] blank_cycles,
  output logic          gate,
  output logic [2:0]    state_o
);
  localparam int NSYNC = 5;

  logic [NSYNC-1:0] raw_in, sync_out;
  logic on_s, off_s, pos_s, sup_s, en_s, en_filt;
  logic mot_last, blk_last, load_mot, load_blk;
  sr_state_e st, nxt;

  assign raw_in = {enable, supply_ok, pos_flag, off_flag, on_flag};

  sr_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(sync_out)
  );

  assign on_s  = sync_out[0];
  assign off_s = sync_out[1];
  assign pos_s = sync_out[2];
  assign sup_s = sync_out[3];
  assign en_s  = sync_out[4];

  sr_en_filter #(.RISE_CYC(EN_RISE_CYC), .FALL_CYC(EN_FALL_CYC)) u_en_filt (
    .clk(clk), .rst(rst), .raw(en_s), .filt(en_filt)
  );

  sr_mask_timer #(.CW(CW)) u_mot (
    .clk(clk), .rst(rst), .load(load_mot), .len(mot_cycles), .last(mot_last)
  );

  sr_mask_timer #(.CW(CW)) u_blank (
    .clk(clk), .rst(rst), .load(load_blk), .len(blank_cycles), .last(blk_last)
  );

  always_comb begin
    nxt = st;
    if (!sup_s) begin
      nxt = ST_LOCKOUT;
    end else if (!en_filt) begin
      nxt = ST_SLEEP;
    end else begin
      unique case (st)
        ST_LOCKOUT, ST_SLEEP: nxt = ST_ARMED;
        ST_ARMED:   if (on_s) nxt = (mot_cycles == '0) ? ST_ON : ST_ON_MASK;
        ST_ON_MASK: if (mot_last) nxt = ST_ON;
        ST_ON:      if (off_s) nxt = (blank_cycles == '0) ? ST_ARMED : ST_BLANK;
        ST_BLANK:   if (pos_s || blk_last) nxt = ST_ARMED;
        default:    nxt = ST_LOCKOUT;
      endcase
    end
  end

  assign load_mot = (st == ST_ARMED) && (nxt == ST_ON_MASK);
  assign load_blk = (st == ST_ON) && (nxt == ST_BLANK);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_LOCKOUT;
      gate <= 1'b0;
    end else begin
      st   <= nxt;
      gate <= (nxt == ST_ON_MASK) || (nxt == ST_ON);
    end
  end

  assign state_o = st;
endmodule

// File: rtl/sr_gate_seq_chk.sv
module sr_gate_seq_chk
  import sr_gate_seq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       on_s,
  input logic       off_s,
  input logic       pos_s,
  input logic       sup_s,
  input logic       en_s,
  input logic       en_filt,
  input logic       gate,
  input logic [2:0] state
);
  logic run;
  assign run = sup_s && en_filt;

  AST_SUPPLY_LOCKOUT: assert property (@(posedge clk) disable iff (rst)
    !sup_s |=> (state == ST_LOCKOUT) && !gate); // R1

  AST_DIRECT_ARM: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_LOCKOUT) || (state == ST_SLEEP)) && run |=> state == ST_ARMED); // R2

  AST_TURN_ON: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARMED) && on_s && run |=> gate); // R3

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ON_MASK) && run |=> gate && ((state == ST_ON_MASK) || (state == ST_ON))); // R4

  AST_TURN_OFF: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ON) && off_s && run |=> !gate); // R5

  AST_BLANK_NO_ON: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BLANK) && run |=> (state == ST_BLANK) || (state == ST_ARMED)); // R6

  AST_EARLY_REARM: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BLANK) && pos_s && run |=> state == ST_ARMED); // R7

  AST_SLEEP_GATE_LOW: assert property (@(posedge clk) disable iff (rst)
    sup_s && !en_filt |=> (state == ST_SLEEP) && !gate); // R8

  AST_FILTER_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !$stable(en_filt) |-> en_filt == $past(en_s)); // R9

  AST_GATE_STATE: assert property (@(posedge clk) disable iff (rst)
    gate == ((state == ST_ON_MASK) || (state == ST_ON))); // R10
endmodule

bind sr_gate_seq sr_gate_seq_chk u_chk (
  .clk(clk), .rst(rst), .on_s(on_s), .off_s(off_s), .pos_s(pos_s),
  .sup_s(sup_s), .en_s(en_s), .en_filt(en_filt), .gate(gate), .state(state_o)
);

// File: tb/sr_gate_seq_test.sv
module sr_gate_seq_test;
  localparam int CW = 8;
  localparam int ER = 20;
  localparam int EF = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 1'b0, enable = 1'b0;
  logic on_flag = 1'b0, off_flag = 1'b0, pos_flag = 1'b0;
  logic [CW-1:0] mot_cycles = '0, blank_cycles = '0;
  logic gate;
  logic [2:0] state_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sr_gate_seq #(.CW(CW), .EN_RISE_CYC(ER), .EN_FALL_CYC(EF)) uut (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .enable(enable),
    .on_flag(on_flag), .off_flag(off_flag), .pos_flag(pos_flag),
    .mot_cycles(mot_cycles), .blank_cycles(blank_cycles),
    .gate(gate), .state_o(state_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_st(input string req, input int exp_s);
    check({req, " state"}, int'(state_o), exp_s);
    check({req, " gate"}, int'(gate), (exp_s == 3 || exp_s == 4) ? 1 : 0);
  endtask

  // expected state j rising edges after on and off flags rise together
  function automatic int exp_state(input int j, input int m, input int b);
    if (j < 3) return 2;
    if (j < 3 + m) return 3;
    if (j == 3 + m) return 4;
    if (j < 4 + m + b) return 5;
    return 2;
  endfunction

  initial begin
    int bl[4] = '{0, 1, 3, 5};
    step(3);
    check_st("R1 reset", 0);
    rst = 1'b0;
    step(5);
    check_st("R1 supply low after reset", 0);

    supply_ok = 1'b1;
    step(2);
    check_st("R1 supply rise not yet due", 0);
    step(1);
    check_st("R8 sleep with enable low", 1);
    on_flag = 1'b1;
    step(6);
    check_st("R8 on flag ignored in sleep", 1);
    on_flag = 1'b0;

    enable = 1'b1;
    step(ER - 1);
    enable = 1'b0;
    step(30);
    check_st("R9 short high pulse ignored", 1);

    enable = 1'b1;
    step(ER + 2);
    check_st("R9 rise not yet due", 1);
    step(1);
    check_st("R9 R2 armed after rise", 2);

    enable = 1'b0;
    step(EF - 1);
    enable = 1'b1;
    step(30);
    check_st("R9 short low pulse ignored", 2);

    for (int m = 0; m <= 4; m++) begin
      for (int bi = 0; bi < 4; bi++) begin
        int b;
        b = bl[bi];
        mot_cycles = CW'(m);
        blank_cycles = CW'(b);
        on_flag = 1'b1;
        off_flag = 1'b1;
        for (int j = 1; j <= 6 + m + b; j++) begin
          step(1);
          if (j == 2) on_flag = 1'b0;
          check_st($sformatf("R3 R4 R5 R6 m=%0d b=%0d j=%0d", m, b, j), exp_state(j, m, b));
        end
        off_flag = 1'b0;
        step(3);
      end
    end

    mot_cycles = CW'(1);
    blank_cycles = CW'(8);
    on_flag = 1'b1;
    off_flag = 1'b1;
    step(2);
    on_flag = 1'b0;
    step(4);
    on_flag = 1'b1;
    off_flag = 1'b0;
    step(6);
    check_st("R6 on held during blank", 5);
    step(1);
    check_st("R6 blank expired", 2);
    step(1);
    check_st("R3 retrigger after blank", 3);
    step(1);
    check_st("R4 one-cycle mask", 4);
    on_flag = 1'b0;
    off_flag = 1'b1;
    step(2);
    check_st("R5 off not yet due", 4);
    step(1);
    check_st("R5 turned off", 5);
    off_flag = 1'b0;
    pos_flag = 1'b1;
    step(2);
    check_st("R7 pos not yet due", 5);
    step(1);
    check_st("R7 early rearm", 2);
    pos_flag = 1'b0;
    step(3);

    mot_cycles = '0;
    blank_cycles = '0;
    on_flag = 1'b1;
    step(3);
    check_st("R3 zero mask goes on", 4);
    supply_ok = 1'b0;
    step(2);
    check_st("R1 drop not yet due", 4);
    step(1);
    check_st("R1 lockout from on", 0);
    on_flag = 1'b0;
    step(3);
    supply_ok = 1'b1;
    step(3);
    check_st("R2 lockout to armed", 2);
    on_flag = 1'b1;
    step(3);
    check_st("R2 no pending blank", 4);

    enable = 1'b0;
    step(EF + 2);
    check_st("R9 fall not yet due", 4);
    step(1);
    check_st("R8 sleep from on", 1);
    enable = 1'b1;
    step(ER + 2);
    check_st("R8 still asleep", 1);
    step(1);
    check_st("R2 sleep to armed", 2);
    step(1);
    check_st("R2 R3 on after wake", 4);
    on_flag = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule